// File: doc/BRIEF.md
# Floating-Point Normalize, Round and Pack Stage

This block is the final stage of a single-precision arithmetic datapath. An adder, multiplier or divider ahead of it delivers a raw result: a sign, a signed exponent with headroom above and below the normal range, and a 32-bit fraction. That fraction need not be normalized, and its lowest 8 bits carry the guard, round and sticky information. The stage shifts the leading one up to the top of the fraction and rounds to nearest with ties to even. It then assembles a 32-bit IEEE-754 single-precision word. If the rounded exponent is outside the normal range, it raises an overflow or underflow flag instead.

The stage has two registers. The first cycle normalizes the fraction. It uses a one-step 16-place skip when the upper half of the fraction is empty, then a priority encoder and a barrel shift. The second cycle rounds, renormalizes when rounding carries out, checks the range and packs the word. A new operand may be presented every cycle, and each result appears exactly two clock edges later. Denormal results and infinities are never generated.

Top module: `fpn_repack`

## Requirements
- R1: A fraction of all zeros yields the word 0x00000000 (+0) with both flags clear, whatever the sign and exponent are.
- R2: A nonzero fraction is shifted left until its bit 31 is 1. The exponent is reduced by one for each place shifted.
- R3: When fraction bits 31:16 are all zero, the fraction moves left 16 places and the exponent drops by 16 in one step, before the remaining shift. A value as small as bit 0 alone normalizes correctly.
- R4: After normalization, if fraction bits 7:0 are all zero, the result is exact and bits 31:8 are packed unchanged.
- R5: Otherwise 0x80 is added to the normalized fraction. Discarded bits above one half round up, and discarded bits below one half round down.
- R6: When the discarded bits equal exactly 0x80 (a tie), bit 8 of the rounded fraction is cleared afterwards, so ties go to an even result.
- R7: When rounding carries out of bit 31, the fraction becomes 1.0 and the exponent rises by one. That raised exponent is the one range-checked and packed.
- R8: A final biased exponent above 254 sets out_ovf. At most one of out_ovf and out_unf is ever set.
- R9: A final biased exponent below 1, including a negative one, sets out_unf.
- R10: A result with no flag is packed as sign in bit 31, biased exponent in bits 30:23, and fraction bits 30:8 (the bits below the hidden leading one) in bits 22:0.
- R11: When either flag is set, out_word is 0x00000000.
- R12: out_valid is asserted exactly two clock edges after in_valid is sampled high. Operands on consecutive cycles produce results on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Sign of the raw result, 1 = negative |
| in_exp | input | 10 | Biased exponent, two's complement signed |
| in_frac | input | 32 | Raw fraction; bits 7:0 are the bits to be rounded off |
| out_valid | output | 1 | Result present this cycle |
| out_word | output | 32 | Packed single-precision result |
| out_ovf | output | 1 | Exponent overflow |
| out_unf | output | 1 | Exponent underflow |

## Verification
The assertions check properties that must hold on every cycle. The normalized fraction held between the two stages always has its top bit set. A zero fraction always leaves as a clean +0. Flags are exclusive and always zero the word. A packed nonzero word always has an exponent field between 1 and 254. out_valid never appears without an operand two edges earlier. Only the bench's scenarios can show the exact rounding decisions: above, below and on the halfway point, with even and odd results. They also cover the carry to 2.0 with its exponent bump, the 16-place skip followed by a further shift, and the exact exponent boundaries at 0, 1, 254 and 255.

// File: rtl/fpn_pkg.sv
package fpn_pkg;
    localparam int FRAC_W   = 32;
    localparam int IN_EXP_W = 10;
    localparam int EXP_W    = 12;
    localparam int SKIP_W   = FRAC_W / 2;
    localparam int DISC_W   = 8;
    localparam int MANT_W   = FRAC_W - DISC_W;
    localparam int LZ_W     = $clog2(SKIP_W);
    localparam int EXP_MAX  = 254;
    localparam int EXP_MIN  = 1;

    typedef struct packed {
        logic                     valid;
        logic                     sign;
        logic                     zero;
        logic signed [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0]        frac;
    } norm_stage_t;

    typedef struct packed {
        logic        valid;
        logic [31:0] word;
        logic        ovf;
        logic        unf;
    } pack_stage_t;
endpackage

// File: rtl/fpn_lshift_norm.sv
module fpn_lshift_norm
    import fpn_pkg::*;
(
    input  logic [FRAC_W-1:0]       frac_i,
    input  logic signed [EXP_W-1:0] exp_i,
    output logic [FRAC_W-1:0]       frac_o,
    output logic signed [EXP_W-1:0] exp_o,
    output logic                    zero_o
);
    logic                    hi_empty;
    logic [FRAC_W-1:0]       skip_frac;
    logic signed [EXP_W-1:0] skip_exp;
    logic [LZ_W-1:0]         lead;
    logic                    hit;

    always_comb begin
        zero_o    = (frac_i == '0);
        hi_empty  = (frac_i[FRAC_W-1 -: SKIP_W] == '0);
        skip_frac = hi_empty ? (frac_i << SKIP_W) : frac_i;
        skip_exp  = hi_empty ? (exp_i - EXP_W'(SKIP_W)) : exp_i;

        lead = '0;
        hit  = 1'b0;
        for (int i = 0; i < SKIP_W; i++) begin
            if (!hit && skip_frac[FRAC_W-1-i]) begin
                lead = LZ_W'(i);
                hit  = 1'b1;
            end
        end

        frac_o = skip_frac << lead;
        exp_o  = skip_exp - $signed({{(EXP_W-LZ_W){1'b0}}, lead});
    end
endmodule

// File: rtl/fpn_round_pack.sv
module fpn_round_pack
    import fpn_pkg::*;
(
    input  logic                    sign_i,
    input  logic                    zero_i,
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [FRAC_W-1:0]       frac_i,
    output logic [31:0]             word_o,
    output logic                    ovf_o,
    output logic                    unf_o
);
    localparam logic [FRAC_W:0] HALF = (FRAC_W+1)'(1) << (DISC_W - 1);

    logic                    inexact;
    logic                    tie;
    logic [FRAC_W:0]         summed;
    logic [MANT_W-1:0]       mant;
    logic signed [EXP_W-1:0] fin_exp;

    always_comb begin
        inexact = (frac_i[DISC_W-1:0] != '0);
        tie     = inexact && (frac_i[DISC_W-2:0] == '0);
        summed  = {1'b0, frac_i} + (inexact ? HALF : '0);
        if (tie) begin
            summed[DISC_W] = 1'b0;
        end

        if (summed[FRAC_W]) begin
            mant    = {1'b1, {(MANT_W-1){1'b0}}};
            fin_exp = exp_i + EXP_W'(1);
        end else begin
            mant    = summed[FRAC_W-1:DISC_W];
            fin_exp = exp_i;
        end

        ovf_o  = !zero_i && (fin_exp > EXP_MAX);
        unf_o  = !zero_i && (fin_exp < EXP_MIN);
        word_o = {sign_i, fin_exp[7:0], mant[MANT_W-2:0]};
        if (zero_i || ovf_o || unf_o) begin
            word_o = '0;
        end
    end
endmodule

// File: rtl/fpn_repack.sv
module fpn_repack
    import fpn_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sign,
    input  logic [9:0]  in_exp,
    input  logic [31:0] in_frac,
    output logic        out_valid,
    output logic [31:0] out_word,
    output logic        out_ovf,
    output logic        out_unf
);
    norm_stage_t s1_d, s1_q;
    pack_stage_t s2_d, s2_q;

    logic [FRAC_W-1:0]       n_frac;
    logic signed [EXP_W-1:0] n_exp;
    logic                    n_zero;
    logic signed [EXP_W-1:0] ext_exp;
    logic [31:0]             p_word;
    logic                    p_ovf;
    logic                    p_unf;

    assign ext_exp = $signed({{(EXP_W-IN_EXP_W){in_exp[IN_EXP_W-1]}}, in_exp});

    fpn_lshift_norm u_norm (
        .frac_i (in_frac),
        .exp_i  (ext_exp),
        .frac_o (n_frac),
        .exp_o  (n_exp),
        .zero_o (n_zero)
    );

    fpn_round_pack u_pack (
        .sign_i (s1_q.sign),
        .zero_i (s1_q.zero),
        .exp_i  (s1_q.exp),
        .frac_i (s1_q.frac),
        .word_o (p_word),
        .ovf_o  (p_ovf),
        .unf_o  (p_unf)
    );

    always_comb begin
        s1_d       = '0;
        s1_d.valid = in_valid;
        if (in_valid) begin
            s1_d.sign = in_sign;
            s1_d.zero = n_zero;
            s1_d.exp  = n_exp;
            s1_d.frac = n_frac;
        end
        s2_d       = '0;
        s2_d.valid = s1_q.valid;
        if (s1_q.valid) begin
            s2_d.word = p_word;
            s2_d.ovf  = p_ovf;
            s2_d.unf  = p_unf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.valid;
    assign out_word  = s2_q.word;
    assign out_ovf   = s2_q.ovf;
    assign out_unf   = s2_q.unf;

    AST_NORM_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && !s1_q.zero) |-> s1_q.frac[FRAC_W-1]); // R2
    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && s1_q.zero) |=> (out_word == 32'h0 && !out_ovf && !out_unf)); // R1
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_ovf && out_unf)); // R8
    AST_FLAG_ZERO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ovf || out_unf) |-> (out_word == 32'h0)); // R11
    AST_EXP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word != 32'h0) |-> (out_word[30:23] >= 8'd1 && out_word[30:23] <= 8'd254)); // R10
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2)); // R12
endmodule

// File: tb/tb_fpn_repack.sv
module tb_fpn_repack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [9:0]  in_exp = '0;
    logic [31:0] in_frac = '0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_ovf;
    logic        out_unf;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fpn_repack dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_frac(in_frac), .out_valid(out_valid),
        .out_word(out_word), .out_ovf(out_ovf), .out_unf(out_unf)
    );

    // {sign, exp[9:0], frac[31:0], expected word[31:0], ovf, unf}
    localparam int NV = 20;
    localparam logic [76:0] VEC [NV] = '{
        {1'b0, 10'd127,  32'h80000000, 32'h3F800000, 2'b00},
        {1'b1, 10'd143,  32'h00008000, 32'hBF800000, 2'b00},
        {1'b0, 10'd129,  32'h40000000, 32'h40000000, 2'b00},
        {1'b0, 10'd127,  32'h800000C0, 32'h3F800001, 2'b00},
        {1'b0, 10'd127,  32'h80000040, 32'h3F800000, 2'b00},
        {1'b0, 10'd127,  32'h80000080, 32'h3F800000, 2'b00},
        {1'b0, 10'd127,  32'h80000180, 32'h3F800002, 2'b00},
        {1'b0, 10'd127,  32'hFFFFFF80, 32'h40000000, 2'b00},
        {1'b0, 10'd255,  32'h80000000, 32'h00000000, 2'b10},
        {1'b0, 10'd254,  32'h80000000, 32'h7F000000, 2'b00},
        {1'b0, 10'd254,  32'hFFFFFFC0, 32'h00000000, 2'b10},
        {1'b0, 10'd1,    32'h80000000, 32'h00800000, 2'b00},
        {1'b0, 10'd0,    32'h80000000, 32'h00000000, 2'b01},
        {1'b0, 10'd1,    32'h40000000, 32'h00000000, 2'b01},
        {1'b0, 10'h3FB,  32'h80000000, 32'h00000000, 2'b01},
        {1'b1, 10'd300,  32'h00000000, 32'h00000000, 2'b00},
        {1'b0, 10'd200,  32'h00000001, 32'h54800000, 2'b00},
        {1'b1, 10'd140,  32'h00ABCDEF, 32'hC22BCDEF, 2'b00},
        {1'b0, 10'd150,  32'h00000123, 32'h3F918000, 2'b00},
        {1'b1, 10'd300,  32'h80000000, 32'h00000000, 2'b10}
    };

    function automatic string tag_of(int i);
        case (i)
            0:                   return "R10";
            1, 16, 18:           return "R3";
            2:                   return "R2";
            3, 4:                return "R5";
            5, 6:                return "R6";
            7, 10:               return "R7";
            8, 9:                return "R8";
            11, 12, 13, 14:      return "R9";
            15:                  return "R1";
            17:                  return "R4";
            default:             return "R11";
        endcase
    endfunction

    task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual word=%h ovf/unf=%b expected word=%h ovf/unf=%b",
                     tag, act[33:2], act[1:0], exp[33:2], exp[1:0]);
        end
    endtask

    task automatic drive(logic [76:0] v);
        in_valid = 1'b1;
        in_sign  = v[76];
        in_exp   = v[75:66];
        in_frac  = v[65:34];
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", {out_valid, out_word, out_ovf}, 34'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            check(tag_of(i), {out_word, out_ovf, out_unf}, VEC[i][33:0]);
            check("R12", {33'h0, out_valid}, 34'h1);
        end

        // R12: output absent after one edge, present after two
        drive(VEC[3]);
        @(negedge clk);
        in_valid = 1'b0;
        check("R12", {33'h0, out_valid}, 34'h0);
        @(negedge clk);
        check("R12", {33'h0, out_valid}, 34'h1);
        @(negedge clk);
        check("R12", {33'h0, out_valid}, 34'h0);

        // R12 back-to-back stream, R6/R7 values
        drive(VEC[6]);
        @(negedge clk);
        drive(VEC[7]);
        @(negedge clk);
        drive(VEC[17]);
        check("R6", {out_word, out_ovf, out_unf}, VEC[6][33:0]);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7", {out_word, out_ovf, out_unf}, VEC[7][33:0]);
        @(negedge clk);
        check("R4", {out_word, out_ovf, out_unf}, VEC[17][33:0]);
        @(negedge clk);

        // R1 zero with negative sign and an underflowing exponent stays clean +0
        drive({1'b1, 10'h200, 32'h0, 34'h0});
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R1", {out_word, out_ovf, out_unf}, 34'h0);

        // R9 skip path driving exponent below 1: bit 0 alone at exponent 31 -> 0
        drive({1'b0, 10'd31, 32'h1, 34'h0});
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9", {out_word, out_ovf, out_unf}, {32'h0, 2'b01});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule